// File: doc/BRIEF.md
# Byte-Fed CRC-16 Register Peripheral

This peripheral sits on a narrow microcontroller register bus and computes a 16-bit cyclic redundancy check over a byte stream. Software first loads a starting value into a 16-bit result register. It does this through two byte-wide halves. Software then writes the data bytes, one at a time, to an 8-bit feed register. Each fed byte is folded into the running checksum. The result register is then overwritten with the new value, so reading it back gives the running CRC at any point.

The datapath uses the polynomial x^16 + x^12 + x^5 + 1. It processes bits least significant first, in the reflected form with constant 0x8408. A byte takes a fixed number of clock cycles: four bits per cycle by default, so two cycles. During those cycles the block raises a busy flag, and the visible result keeps its old value. A byte fed while the engine is busy waits in a one-entry holding slot. A byte fed while that slot is full is discarded, and a sticky overflow flag records the loss. Writing either half of the result register aborts any update in progress. It also empties the holding slot and clears the overflow flag.

Top module: `crc16_mmio`

## Requirements
- R1: The update is the bit-serial reflected CRC. For each byte bit from bit 0 upward: fb = crc[0] ^ d[i], then crc = (crc >> 1) ^ (fb ? 16'h8408 : 0).
- R2: The register select is addr_i: 0 selects the result low byte, 1 the result high byte and 2 the feed register. rdata_o shows the selected register combinationally. Address 2 reads back the last byte written there, and address 3 reads 0.
- R3: A write to address 0 or 1 replaces only that byte of the result register. The other byte keeps its value.
- R4: A feed write sampled at clock edge N sets busy_o after edge N and holds it through edge N+1. After edge N+2 busy_o is low and the result register holds the updated CRC.
- R5: While a byte is in progress, the result register reads the value it had before the feed write.
- R6: Consecutive feed writes chain. Each one updates the CRC produced by the previous one.
- R7: A feed write accepted while busy is kept and processed straight after the current byte, without losing a cycle. Three writes on consecutive cycles complete 6 edges after the first write.
- R8: A feed write that arrives while busy, in a cycle that is not the final cycle of a byte and with the holding slot full, is dropped and sets ovf_o. ovf_o stays set until the next result-register write clears it.
- R9: A result-register write during a byte update cancels that update and any held byte. busy_o is low after that edge, and no later commit overwrites the new value.
- R10: After reset, busy_o and ovf_o are low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| we_i | input | 1 | Register write strobe |
| addr_i | input | 2 | Register select |
| wdata_i | input | 8 | Write data byte |
| rdata_o | output | 8 | Read data for addr_i |
| busy_o | output | 1 | A byte is being folded in |
| ovf_o | output | 1 | Sticky: a fed byte was dropped |

## Verification
The bench builds the block with its defaults: 8-bit bytes, four bits per cycle and the reflected constant 0x8408. That gives a two-cycle byte. With a two-cycle byte, a single extra write can be absorbed by the holding slot, and a fourth consecutive write is the first one that can overflow. These defaults also open the window where a seed write lands between the two update steps of a byte. Fixed seed/byte vectors and a chained random stream are compared against a bit-serial model in the bench.

// File: rtl/crc16_pkg.sv
package crc16_pkg;
  typedef enum logic [1:0] {
    SEL_RES_LO = 2'd0,
    SEL_RES_HI = 2'd1,
    SEL_FEED   = 2'd2,
    SEL_NONE   = 2'd3
  } reg_sel_e;

  function automatic reg_sel_e decode_sel(input logic [1:0] addr);
    case (addr)
      2'd0:    decode_sel = SEL_RES_LO;
      2'd1:    decode_sel = SEL_RES_HI;
      2'd2:    decode_sel = SEL_FEED;
      default: decode_sel = SEL_NONE;
    endcase
  endfunction
endpackage

// File: rtl/crc16_step.sv
// Folds BITS data bits into the CRC, LSB first, reflected polynomial.
module crc16_step #(
  parameter int unsigned W    = 16,
  parameter int unsigned BITS = 4,
  parameter logic [W-1:0] POLY = 16'h8408
) (
  input  logic [W-1:0]    crc_i,
  input  logic [BITS-1:0] dat_i,
  output logic [W-1:0]    crc_o
);
  logic [W-1:0] chain [0:BITS];

  assign chain[0] = crc_i;

  for (genvar i = 0; i < BITS; i++) begin : g_bit
    logic fb;
    assign fb = chain[i][0] ^ dat_i[i];
    assign chain[i+1] = (chain[i] >> 1) ^ ({W{fb}} & POLY);
  end

  assign crc_o = chain[BITS];
endmodule

// File: rtl/crc16_ctrl.sv
// Sequencer: per-byte step counter, one-entry holding slot, overflow.
module crc16_ctrl #(
  parameter int unsigned W      = 16,
  parameter int unsigned BYTE_W = 8,
  parameter int unsigned BITS   = 4,
  parameter logic [W-1:0] POLY  = 16'h8408
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              feed_i,
  input  logic              cancel_i,
  input  logic [BYTE_W-1:0] byte_i,
  input  logic [W-1:0]      seed_i,
  output logic              busy_o,
  output logic              done_o,
  output logic [W-1:0]      result_o,
  output logic              ovf_o
);
  localparam int unsigned STEPS = BYTE_W / BITS;
  localparam int unsigned CNT_W = (STEPS > 1) ? $clog2(STEPS) : 1;
  localparam logic [CNT_W-1:0] LAST_CNT = CNT_W'(STEPS - 1);

  logic              active_q;
  logic [CNT_W-1:0]  cnt_q;
  logic [BYTE_W-1:0] sh_q;
  logic [W-1:0]      work_q;
  logic              hold_v_q;
  logic [BYTE_W-1:0] hold_d_q;
  logic              ovf_q;
  logic [W-1:0]      nxt;
  logic              last;

  crc16_step #(.W(W), .BITS(BITS), .POLY(POLY)) u_step (
    .crc_i (work_q),
    .dat_i (sh_q[BITS-1:0]),
    .crc_o (nxt)
  );

  assign last = active_q && (cnt_q == LAST_CNT);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      active_q <= 1'b0;
      cnt_q    <= '0;
      sh_q     <= '0;
      work_q   <= '0;
      hold_v_q <= 1'b0;
      hold_d_q <= '0;
      ovf_q    <= 1'b0;
    end else if (cancel_i) begin
      active_q <= 1'b0;
      cnt_q    <= '0;
      hold_v_q <= 1'b0;
      ovf_q    <= 1'b0;
    end else if (!active_q) begin
      if (feed_i) begin
        active_q <= 1'b1;
        cnt_q    <= '0;
        sh_q     <= byte_i;
        work_q   <= seed_i;
      end
    end else if (!last) begin
      cnt_q  <= cnt_q + 1'b1;
      work_q <= nxt;
      sh_q   <= sh_q >> BITS;
      if (feed_i) begin
        if (hold_v_q) begin
          ovf_q <= 1'b1;
        end else begin
          hold_v_q <= 1'b1;
          hold_d_q <= byte_i;
        end
      end
    end else begin
      // final step: chain straight into the next byte when one is waiting
      cnt_q  <= '0;
      work_q <= nxt;
      if (hold_v_q) begin
        sh_q     <= hold_d_q;
        hold_v_q <= feed_i;
        hold_d_q <= byte_i;
      end else if (feed_i) begin
        sh_q <= byte_i;
      end else begin
        active_q <= 1'b0;
      end
    end
  end

  assign busy_o   = active_q;
  assign done_o   = last && !cancel_i;
  assign result_o = nxt;
  assign ovf_o    = ovf_q;
endmodule

// File: rtl/crc16_mmio.sv
module crc16_mmio #(
  parameter int unsigned BYTE_W       = 8,
  parameter int unsigned BITS_PER_CYC = 4,
  parameter logic [2*BYTE_W-1:0] POLY = 16'h8408
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [1:0]        addr_i,
  input  logic [BYTE_W-1:0] wdata_i,
  output logic [BYTE_W-1:0] rdata_o,
  output logic              busy_o,
  output logic              ovf_o
);
  import crc16_pkg::*;

  localparam int unsigned CRC_W = 2 * BYTE_W;

  reg_sel_e          sel;
  logic              wr_lo;
  logic              wr_hi;
  logic              wr_feed;
  logic [CRC_W-1:0]  crc_q;
  logic [BYTE_W-1:0] feed_q;
  logic              done;
  logic [CRC_W-1:0]  result;

  assign sel     = decode_sel(addr_i);
  assign wr_lo   = we_i && (sel == SEL_RES_LO);
  assign wr_hi   = we_i && (sel == SEL_RES_HI);
  assign wr_feed = we_i && (sel == SEL_FEED);

  crc16_ctrl #(
    .W      (CRC_W),
    .BYTE_W (BYTE_W),
    .BITS   (BITS_PER_CYC),
    .POLY   (POLY)
  ) u_ctrl (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .feed_i   (wr_feed),
    .cancel_i (wr_lo || wr_hi),
    .byte_i   (wdata_i),
    .seed_i   (crc_q),
    .busy_o   (busy_o),
    .done_o   (done),
    .result_o (result),
    .ovf_o    (ovf_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      crc_q  <= '0;
      feed_q <= '0;
    end else begin
      if (wr_lo)       crc_q[BYTE_W-1:0]     <= wdata_i;
      else if (wr_hi)  crc_q[CRC_W-1:BYTE_W] <= wdata_i;
      else if (done)   crc_q                 <= result;
      if (wr_feed)     feed_q                <= wdata_i;
    end
  end

  always_comb begin
    case (sel)
      SEL_RES_LO: rdata_o = crc_q[BYTE_W-1:0];
      SEL_RES_HI: rdata_o = crc_q[CRC_W-1:BYTE_W];
      SEL_FEED:   rdata_o = feed_q;
      default:    rdata_o = '0;
    endcase
  end
endmodule

// File: rtl/crc16_mmio_chk.sv
module crc16_mmio_chk #(
  parameter int unsigned BYTE_W       = 8,
  parameter int unsigned BITS_PER_CYC = 4
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              we_i,
  input logic [1:0]        addr_i,
  input logic [BYTE_W-1:0] wdata_i,
  input logic              busy_o,
  input logic              ovf_o,
  input logic [2*BYTE_W-1:0] crc_i
);
  localparam int unsigned STEPS = BYTE_W / BITS_PER_CYC;

  logic seed_wr;
  logic feed_wr;
  assign seed_wr = we_i && (addr_i == 2'd0 || addr_i == 2'd1);
  assign feed_wr = we_i && (addr_i == 2'd2);

  AST_FEED_STARTS_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (feed_wr && !busy_o) |=> busy_o); // R4

  if (STEPS > 1) begin : g_multi
    AST_RESULT_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (busy_o && !$past(busy_o) && !seed_wr) |=> $stable(crc_i)); // R5
  end

  AST_SEED_HI: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && addr_i == 2'd1) |=> (crc_i[2*BYTE_W-1:BYTE_W] == $past(wdata_i))); // R3

  AST_OVF_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ovf_o && !seed_wr) |=> ovf_o); // R8

  AST_NO_OVERFLOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_o && !ovf_o && !seed_wr) |=> !ovf_o); // R8

  AST_SEED_CANCEL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    seed_wr |=> (!busy_o && !ovf_o)); // R9
endmodule

bind crc16_mmio crc16_mmio_chk #(
  .BYTE_W       (BYTE_W),
  .BITS_PER_CYC (BITS_PER_CYC)
) u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .we_i    (we_i),
  .addr_i  (addr_i),
  .wdata_i (wdata_i),
  .busy_o  (busy_o),
  .ovf_o   (ovf_o),
  .crc_i   (crc_q)
);

// File: tb/crc16_mmio_tb.sv
`timescale 1ns/1ps
module crc16_mmio_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       we = 1'b0;
  logic [1:0] addr = 2'd3;
  logic [7:0] wdata = '0;
  logic [7:0] rdata;
  logic       busy;
  logic       ovf;

  int n_tests = 0;
  int n_fail  = 0;

  always #2 clk = ~clk;

  crc16_mmio u_dut (
    .clk_i   (clk),
    .rst_ni  (rst_n),
    .we_i    (we),
    .addr_i  (addr),
    .wdata_i (wdata),
    .rdata_o (rdata),
    .busy_o  (busy),
    .ovf_o   (ovf)
  );

  // {seed, byte}
  localparam logic [23:0] VEC [0:7] = '{
    24'hFFFF_00, 24'h0000_31, 24'h1D0F_A5, 24'h8408_FF,
    24'h0001_80, 24'hFFFF_FF, 24'h1234_56, 24'hBEEF_01
  };

  function automatic logic [15:0] ref_crc(input logic [15:0] c, input logic [7:0] d);
    logic [15:0] r = c;
    for (int i = 0; i < 8; i++) begin
      logic fb = r[0] ^ d[i];
      r = r >> 1;
      if (fb) r = r ^ 16'h8408;
    end
    return r;
  endfunction

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // Called at a negedge; returns at the next negedge.
  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    we = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    we = 1'b0; addr = 2'd3;
  endtask

  task automatic rd16(output logic [15:0] v);
    addr = 2'd0; #0.3; v[7:0]  = rdata;
    addr = 2'd1; #0.3; v[15:8] = rdata;
    addr = 2'd3;
  endtask

  task automatic seed(input logic [15:0] s);
    wr(2'd0, s[7:0]);
    wr(2'd1, s[15:8]);
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    logic [15:0] v, e, s;
    idle(2);
    rst_n = 1'b1;
    idle(1);
    chk("R10 busy after reset", {15'd0, busy}, 16'd0);
    chk("R10 ovf after reset", {15'd0, ovf}, 16'd0);

    // vector table: one byte per seed
    for (int k = 0; k < 8; k++) begin
      seed(VEC[k][23:8]);
      wr(2'd2, VEC[k][7:0]);
      idle(2);
      rd16(v);
      chk("R1 single byte", v, ref_crc(VEC[k][23:8], VEC[k][7:0]));
    end

    // R3: half writes
    seed(16'h1234);
    rd16(v); chk("R3 seed both halves", v, 16'h1234);
    wr(2'd1, 8'hAB);
    rd16(v); chk("R3 high only", v, 16'hAB34);
    wr(2'd0, 8'h5C);
    rd16(v); chk("R3 low only", v, 16'hAB5C);

    // R2: feed readback and unused address
    wr(2'd2, 8'h6E);
    addr = 2'd2; #0.3; chk("R2 feed readback", {8'd0, rdata}, 16'h006E);
    addr = 2'd3; #0.3; chk("R2 unused address", {8'd0, rdata}, 16'h0000);
    idle(3);

    // R4/R5: timing and read-while-busy
    seed(16'hC0DE);
    wr(2'd2, 8'h42);
    chk("R4 busy after edge N", {15'd0, busy}, 16'd1);
    rd16(v); chk("R5 old value after edge N", v, 16'hC0DE);
    idle(1);
    chk("R4 busy after edge N+1", {15'd0, busy}, 16'd1);
    rd16(v); chk("R5 old value after edge N+1", v, 16'hC0DE);
    idle(1);
    chk("R4 idle after edge N+2", {15'd0, busy}, 16'd0);
    rd16(v); chk("R4 new value after edge N+2", v, ref_crc(16'hC0DE, 8'h42));

    // R6: chained random stream with gaps
    s = 16'($urandom);
    seed(s);
    e = s;
    for (int k = 0; k < 24; k++) begin
      logic [7:0] b = 8'($urandom);
      wr(2'd2, b);
      e = ref_crc(e, b);
      idle(2 + (k % 3));
    end
    rd16(v); chk("R6 chained stream", v, e);

    // R7: three writes on consecutive cycles
    seed(16'hFFFF);
    wr(2'd2, 8'h11); wr(2'd2, 8'h22); wr(2'd2, 8'h33);
    e = ref_crc(ref_crc(ref_crc(16'hFFFF, 8'h11), 8'h22), 8'h33);
    idle(3);
    chk("R7 still busy at N+5", {15'd0, busy}, 16'd1);
    idle(1);
    chk("R7 done at N+6", {15'd0, busy}, 16'd0);
    rd16(v); chk("R7 queued bytes", v, e);
    chk("R7 no overflow", {15'd0, ovf}, 16'd0);

    // R8: fourth consecutive write is dropped
    seed(16'h0F0F);
    wr(2'd2, 8'hA1); wr(2'd2, 8'hB2); wr(2'd2, 8'hC3); wr(2'd2, 8'hD4);
    idle(8);
    e = ref_crc(ref_crc(ref_crc(16'h0F0F, 8'hA1), 8'hB2), 8'hC3);
    rd16(v); chk("R8 dropped byte", v, e);
    chk("R8 overflow set", {15'd0, ovf}, 16'd1);
    wr(2'd2, 8'h00); idle(3);
    chk("R8 overflow sticky", {15'd0, ovf}, 16'd1);
    wr(2'd0, 8'h00);
    chk("R8 overflow cleared by seed", {15'd0, ovf}, 16'd0);

    // R9: seed write mid-update cancels byte and held byte
    seed(16'h1111);
    wr(2'd2, 8'h77); wr(2'd2, 8'h88);
    wr(2'd0, 8'h99);
    chk("R9 busy cleared", {15'd0, busy}, 16'd0);
    wr(2'd1, 8'h55);
    idle(4);
    rd16(v); chk("R9 seed survives", v, 16'h5599);
    chk("R9 still idle", {15'd0, busy}, 16'd0);

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule